// File: doc/BRIEF.md
# Fixed-Priority Restart Interrupt Controller

This block sits beside an instruction sequencer. It decides which of five interrupt sources, if any, is taken at an instruction boundary. The sources are a nonmaskable trap, three restart lines (levels 7.5, 6.5 and 5.5) and a general request line. The sequencer pulses a sample strobe in the next-to-last clock of every instruction. Only at that strobe are pending requests weighed against the software enable and the three restart masks.

A restart source or the trap, once taken, produces a one-cycle vector-valid pulse together with its fixed restart address. A general request, once taken, produces a one-cycle acknowledge pulse instead. The sequencer uses that pulse to hold the program counter and replace the next read with an acknowledge cycle. Any acceptance clears the enable. Software sets the enable again with an enable pulse, clears it with a disable pulse, and writes the masks through a mask-write port. A status port shows the enable, the masks and every pending request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When several requests qualify at a strobe, exactly one is taken, in the order trap, 7.5, 6.5, 5.5, general. The vectors are 0x0024 (trap), 0x003C (7.5), 0x0034 (6.5) and 0x002C (5.5).
- R2: Requests are weighed only at a clock edge where `sample_i` is high. The result (`vec_valid_o` or `ack_o`) appears for exactly one cycle, in the cycle after that edge. With `sample_i` low, nothing is taken and the enable is left unchanged.
- R3: The trap is taken whatever the enable and the masks hold.
- R4: A restart line is taken only when the enable is set and its mask bit is 0. `mask_data_i` bit 2 masks 7.5, bit 1 masks 6.5 and bit 0 masks 5.5, and a write takes effect from the next edge.
- R5: The enable (status bit 8) is 0 after reset and right after any acceptance. `ei_i` sets it, `di_i` clears it, and the general request also needs it set.
- R6: Taking the general request pulses `ack_o` and leaves `vec_valid_o` low.
- R7: The trap is taken only after a 0-to-1 transition that is still high at the strobe. A trap held high after acceptance is not taken again, and a trap pulse that has ended before the strobe is not taken.
- R8: The 7.5 line latches a rising edge even while masked. The latch stays pending (status bit 3) until it is taken or until a mask write with `clr75_i` high clears it.
- R9: Reset sets all three masks and clears the trap and 7.5 latches and the enable. Status then reads `{1'b0, 3'b111, 5'b0}` with the request inputs low.
- R10: Taking a source does not block lower ones. After the enable is set again, a lower-priority source that is still pending is taken at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_i | input | 1 | Strobe in the next-to-last clock of an instruction |
| trap_i | input | 1 | Nonmaskable trap request |
| rst75_i | input | 1 | Restart 7.5 request, edge-latched |
| rst65_i | input | 1 | Restart 6.5 request, level |
| rst55_i | input | 1 | Restart 5.5 request, level |
| intr_i | input | 1 | General interrupt request, level |
| ei_i | input | 1 | Set the interrupt enable |
| di_i | input | 1 | Clear the interrupt enable |
| mask_wr_i | input | 1 | Write the restart masks |
| mask_data_i | input | 3 | Mask bits {7.5, 6.5, 5.5} |
| clr75_i | input | 1 | With `mask_wr_i`, clear the 7.5 latch |
| vec_valid_o | output | 1 | One-cycle pulse: a vector was taken |
| vector_o | output | 16 | Restart address, valid with `vec_valid_o` |
| ack_o | output | 1 | One-cycle pulse: general request taken |
| status_o | output | 9 | {enable, mask[2:0], trap pend, 7.5 pend, 6.5, 5.5, general} |

## Verification
Every acceptance result is registered. It therefore appears exactly one cycle after the edge at which `sample_i` was seen high, and lasts one cycle. Mask writes, enable changes and edge latches act from the edge after they are driven, so a strobe placed one cycle later already sees them. The driver raises the strobe on a falling edge and queues the expected result, or an explicit "nothing taken", due on the following cycle. The monitor compares on each later falling edge and also flags any pulse that no queued item accounts for. Status reads, taken between strobes, show what a strobe left untouched.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int VW = 16,
  parameter logic [VW-1:0] VEC_TRAP = 16'h0024,
  parameter logic [VW-1:0] VEC_R75  = 16'h003C,
  parameter logic [VW-1:0] VEC_R65  = 16'h0034,
  parameter logic [VW-1:0] VEC_R55  = 16'h002C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_i,
  input  logic          trap_i,
  input  logic          rst75_i,
  input  logic          rst65_i,
  input  logic          rst55_i,
  input  logic          intr_i,
  input  logic          ei_i,
  input  logic          di_i,
  input  logic          mask_wr_i,
  input  logic [2:0]    mask_data_i,
  input  logic          clr75_i,
  output logic          vec_valid_o,
  output logic [VW-1:0] vector_o,
  output logic          ack_o,
  output logic [8:0]    status_o
);

  logic       ie_q;
  logic [2:0] mask_q;
  logic       trap_prev, trap_lat, r75_prev, r75_lat;
  logic [4:0] req, sel;
  logic       take;

  assign req[4] = trap_lat & trap_i;
  assign req[3] = ie_q & ~mask_q[2] & r75_lat;
  assign req[2] = ie_q & ~mask_q[1] & rst65_i;
  assign req[1] = ie_q & ~mask_q[0] & rst55_i;
  assign req[0] = ie_q & intr_i;

  always_comb begin
    sel = '0;
    if      (req[4]) sel[4] = 1'b1;
    else if (req[3]) sel[3] = 1'b1;
    else if (req[2]) sel[2] = 1'b1;
    else if (req[1]) sel[1] = 1'b1;
    else if (req[0]) sel[0] = 1'b1;
  end

  assign take     = sample_i & (|req);
  assign status_o = {ie_q, mask_q, trap_lat & trap_i, r75_lat, rst65_i, rst55_i, intr_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q        <= 1'b0;
      mask_q      <= 3'b111;
      trap_prev   <= 1'b0;
      trap_lat    <= 1'b0;
      r75_prev    <= 1'b0;
      r75_lat     <= 1'b0;
      vec_valid_o <= 1'b0;
      ack_o       <= 1'b0;
      vector_o    <= '0;
    end else begin
      trap_prev <= trap_i;
      r75_prev  <= rst75_i;
      trap_lat  <= trap_i & (trap_lat | ~trap_prev) & ~(take & sel[4]);
      if (rst75_i & ~r75_prev)                          r75_lat <= 1'b1;
      else if ((take & sel[3]) | (mask_wr_i & clr75_i)) r75_lat <= 1'b0;
      if (mask_wr_i) mask_q <= mask_data_i;
      if (take)      ie_q <= 1'b0;
      else if (di_i) ie_q <= 1'b0;
      else if (ei_i) ie_q <= 1'b1;
      vec_valid_o <= take & ~sel[0];
      ack_o       <= take & sel[0];
      if (take & ~sel[0])
        vector_o <= sel[4] ? VEC_TRAP : sel[3] ? VEC_R75 : sel[2] ? VEC_R65 : VEC_R55;
    end
  end

  p_one_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid_o && ack_o));
  p_only_at_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o || ack_o) |-> $past(sample_i));
  p_ie_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o || ack_o) |-> !ie_q);
  p_ack_needs_intr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(intr_i));
  p_trap_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vector_o == VEC_TRAP) |-> $past(trap_i));
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mask_wr_i) |-> $stable(mask_q));

endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_i = 0, trap_i = 0, rst75_i = 0, rst65_i = 0, rst55_i = 0, intr_i = 0;
  logic ei_i = 0, di_i = 0, mask_wr_i = 0, clr75_i = 0;
  logic [2:0] mask_data_i = 3'b000;
  logic vec_valid_o, ack_o;
  logic [15:0] vector_o;
  logic [8:0] status_o;

  int checks = 0, errors = 0, cyc = 0;
  int q_due[$];
  int q_kind[$];
  logic [15:0] q_vec[$];
  string q_tag[$];

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .trap_i(trap_i), .rst75_i(rst75_i),
    .rst65_i(rst65_i), .rst55_i(rst55_i), .intr_i(intr_i), .ei_i(ei_i), .di_i(di_i),
    .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i), .clr75_i(clr75_i),
    .vec_valid_o(vec_valid_o), .vector_o(vector_o), .ack_o(ack_o), .status_o(status_o));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // kind: 0 nothing taken, 1 vector, 2 acknowledge
  always @(negedge clk) begin
    int got;
    got = vec_valid_o ? 1 : (ack_o ? 2 : 0);
    if (rst_n) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        int k;
        logic [15:0] v;
        string t;
        k = q_kind.pop_front(); v = q_vec.pop_front(); t = q_tag.pop_front();
        void'(q_due.pop_front());
        checks++;
        if (got != k || (k == 1 && vector_o != v)) begin
          errors++;
          $display("FAIL %s: kind %0d vector %h, expected kind %0d vector %h", t, got, vector_o, k, v);
        end
      end else if (got != 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected result kind %0d vector %h, expected none", got, vector_o);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(int kind, logic [15:0] vec, string tag);
    sample_i = 1'b1;
    q_due.push_back(cyc + 1); q_kind.push_back(kind); q_vec.push_back(vec); q_tag.push_back(tag);
    tick();
    sample_i = 1'b0;
    tick();
  endtask

  task automatic enable();
    ei_i = 1'b1; tick(); ei_i = 1'b0;
  endtask

  task automatic set_mask(logic [2:0] m, logic clr);
    mask_wr_i = 1'b1; mask_data_i = m; clr75_i = clr; tick();
    mask_wr_i = 1'b0; clr75_i = 1'b0;
  endtask

  task automatic check_status(logic [8:0] exp, string tag);
    checks++;
    if (status_o !== exp) begin
      errors++;
      $display("FAIL %s: status %b, expected %b", tag, status_o, exp);
    end
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_sim();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    check_status({1'b0, 3'b111, 5'b00000}, "R9 reset state");

    // masked and disabled: nothing taken
    intr_i = 1; rst55_i = 1; rst65_i = 1; tick();
    strobe(0, 16'h0, "R4 masked and disabled");
    check_status({1'b0, 3'b111, 5'b00111}, "R4 status");

    // unmask, enable: 6.5 wins over 5.5 and general
    set_mask(3'b000, 1'b0); enable();
    strobe(1, 16'h0034, "R1 6.5 over 5.5/general");
    check_status({1'b0, 3'b000, 5'b00111}, "R5 enable cleared on accept");
    strobe(0, 16'h0, "R5 no accept while disabled");

    // R10: lower levels accepted after re-enable
    enable(); rst65_i = 0; tick();
    strobe(1, 16'h002C, "R10 5.5 after re-enable");
    rst55_i = 0; enable();
    strobe(2, 16'h0, "R6 general acknowledge");

    // R2: no strobe, nothing taken, enable kept
    enable(); tick(3);
    check_status({1'b1, 3'b000, 5'b00001}, "R2 enable kept without strobe");
    strobe(2, 16'h0, "R2 general at strobe");
    intr_i = 0;

    // R3: trap ignores enable and masks
    set_mask(3'b111, 1'b0);
    trap_i = 1; tick();
    strobe(1, 16'h0024, "R3 trap while masked/disabled");
    enable();
    strobe(0, 16'h0, "R7 held trap not retaken");
    check_status({1'b1, 3'b111, 5'b00000}, "R7 enable untouched by held trap");
    trap_i = 0; tick();

    // R7: pulse ended before strobe
    trap_i = 1; tick(); trap_i = 0;
    strobe(0, 16'h0, "R7 ended trap pulse");

    // R8: 7.5 latched while masked
    rst75_i = 1; tick(); rst75_i = 0; tick();
    check_status({1'b1, 3'b111, 5'b01000}, "R8 latch while masked");
    strobe(0, 16'h0, "R4 7.5 masked");
    set_mask(3'b000, 1'b0);
    strobe(1, 16'h003C, "R8 7.5 after unmask");
    check_status({1'b0, 3'b000, 5'b00000}, "R8 latch cleared on accept");

    // R8: software clear
    rst75_i = 1; tick(); rst75_i = 0;
    set_mask(3'b000, 1'b1);
    check_status({1'b0, 3'b000, 5'b00000}, "R8 software clear");
    enable();
    strobe(0, 16'h0, "R8 cleared latch not taken");

    // R1: all sources at once, full chain
    rst55_i = 1; rst65_i = 1; intr_i = 1; rst75_i = 1; trap_i = 1; tick();
    strobe(1, 16'h0024, "R1 trap highest");
    enable();
    strobe(1, 16'h003C, "R1 7.5 second");
    enable();
    strobe(1, 16'h0034, "R1 6.5 third");
    rst65_i = 0; enable();
    strobe(1, 16'h002C, "R1 5.5 fourth");
    rst55_i = 0; enable();
    strobe(2, 16'h0, "R1 general last");
    trap_i = 0; rst75_i = 0; intr_i = 0;

    // R4: one mask bit only
    set_mask(3'b010, 1'b0); rst65_i = 1; rst55_i = 1; enable();
    strobe(1, 16'h002C, "R4 6.5 masked, 5.5 taken");

    // R5: disable after enable
    enable(); di_i = 1; tick(); di_i = 0;
    check_status({1'b0, 3'b010, 5'b00110}, "R5 disable");
    strobe(0, 16'h0, "R5 no accept after disable");
    rst65_i = 0; rst55_i = 0;

    tick(3);
    if (q_due.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: %0d results missing, expected 0", q_due.size());
    end
    finish_sim();
  end
endmodule